// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single load-reserved reservation of one hart and judges every store-conditional that hart issues. A load-reserved strobe stores its address and arms the reservation. A store-conditional strobe is answered in the same cycle with a pass or fail flag. The flag passes only when a reservation is armed and the two addresses fall in the same reservation granule. After every store-conditional the reservation is disarmed.

Several events disarm the reservation. These are a trap being taken, a trap-return instruction, an external keep line being pulled low, and optionally an atomic memory operation. The armed address can be observed at all times; while nothing is armed it reads as all ones. The granule size and the atomic-operation policy are parameters. The block does not touch memory, does not snoop coherence traffic and does not arbitrate between harts.

Top module: `resv_monitor`

## Requirements
- R1: A cycle with `lr_fire` high arms the reservation, and from the next cycle `resv_addr` equals the `lr_addr` of that cycle.
- R2: `sc_ok` is high in the cycle of `sc_fire` exactly when a reservation is armed and `sc_addr` equals the stored address after the low log2(`GRANULE_BYTES`) bits of both are ignored (`GRANULE_BYTES` is a power of two, default 1).
- R3: A `sc_fire` cycle without `lr_fire` leaves the reservation disarmed from the next cycle, whether the store-conditional passed or failed.
- R4: A store-conditional issued while no reservation is armed always fails.
- R5: `resv_keep` low in a cycle without `lr_fire` disarms the reservation from the next cycle.
- R6: `trap_take` or `trap_ret` high in a cycle without `lr_fire` disarms the reservation from the next cycle.
- R7: With `AMO_CANCELS` = 1, `amo_fire` disarms the reservation as in R6. With `AMO_CANCELS` = 0 (default), `amo_fire` leaves the armed address unchanged.
- R8: `resv_addr` reads all ones whenever no reservation is armed.
- R9: Reset (`rst_n` low) disarms the reservation.
- R10: When `lr_fire` coincides with any disarming event (store-conditional, trap, trap return, keep low, atomic operation), the new reservation from that load-reserved survives. A coinciding store-conditional is still judged against the previously armed reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_fire | input | 1 | Load-reserved executes this cycle |
| lr_addr | input | ADDR_W | Load-reserved address |
| sc_fire | input | 1 | Store-conditional executes this cycle |
| sc_addr | input | ADDR_W | Store-conditional address |
| amo_fire | input | 1 | Atomic memory operation executes this cycle |
| trap_take | input | 1 | Exception or interrupt taken this cycle |
| trap_ret | input | 1 | Trap-return instruction executes this cycle |
| resv_keep | input | 1 | External keep line; low disarms the reservation |
| sc_ok | output | 1 | Store-conditional outcome, same cycle as `sc_fire` |
| resv_addr | output | ADDR_W | Armed address, all ones when disarmed |

## Verification
The bench drives two instances from the same stimulus. One is built with an 8-byte granule and atomic operations ignored. The other uses a 1-byte granule with atomic operations cancelling. One store-conditional address can therefore pass on the wide granule and fail on the narrow one, which exposes a wrong mask width. One atomic strobe shows both policies side by side. Coinciding load-reserved and cancel events are driven on both builds.

// File: rtl/resv_pkg.sv
package resv_pkg;

    // Action applied to the reservation register in a cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ARM  = 2'd1,
        ACT_DROP = 2'd2
    } resv_act_e;

    function automatic int unsigned granule_shift(input int unsigned bytes);
        return $clog2(bytes);
    endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned GRANULE_BYTES = 1
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same
);
    localparam int unsigned SHIFT = resv_pkg::granule_shift(GRANULE_BYTES);

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] diff;

    generate
        if (SHIFT == 0) begin : g_byte
            assign keep_mask = '1;
        end else begin : g_wide
            assign keep_mask = {{(ADDR_W-SHIFT){1'b1}}, {SHIFT{1'b0}}};
        end
    endgenerate

    assign diff = (addr_a ^ addr_b) & keep_mask;
    assign same = (diff == '0);
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl #(
    parameter bit AMO_CANCELS = 1'b0
) (
    input  logic                lr_fire,
    input  logic                sc_fire,
    input  logic                amo_fire,
    input  logic                trap_take,
    input  logic                trap_ret,
    input  logic                resv_keep,
    output resv_pkg::resv_act_e act
);
    logic amo_kill;
    logic kill;

    generate
        if (AMO_CANCELS) begin : g_amo_kill
            assign amo_kill = amo_fire;
        end else begin : g_amo_pass
            assign amo_kill = 1'b0;
        end
    endgenerate

    assign kill = sc_fire | trap_take | trap_ret | ~resv_keep | amo_kill;

    always_comb begin
        if (lr_fire)   act = resv_pkg::ACT_ARM;
        else if (kill) act = resv_pkg::ACT_DROP;
        else           act = resv_pkg::ACT_HOLD;
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned GRANULE_BYTES = 1,
    parameter bit          AMO_CANCELS   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_fire,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_fire,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              amo_fire,
    input  logic              trap_take,
    input  logic              trap_ret,
    input  logic              resv_keep,
    output logic              sc_ok,
    output logic [ADDR_W-1:0] resv_addr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } resv_state_t;

    generate
        if ((GRANULE_BYTES == 0) || ((GRANULE_BYTES & (GRANULE_BYTES - 1)) != 0)) begin : g_bad_granule
            $error("GRANULE_BYTES must be a power of two");
        end
    endgenerate

    resv_state_t         st_d, st_q;
    resv_pkg::resv_act_e act;
    logic                addr_same;
    logic                valid_q;

    resv_match #(.ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES)) u_match (
        .addr_a (sc_addr),
        .addr_b (st_q.addr),
        .same   (addr_same)
    );

    resv_ctrl #(.AMO_CANCELS(AMO_CANCELS)) u_ctrl (
        .lr_fire   (lr_fire),
        .sc_fire   (sc_fire),
        .amo_fire  (amo_fire),
        .trap_take (trap_take),
        .trap_ret  (trap_ret),
        .resv_keep (resv_keep),
        .act       (act)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            resv_pkg::ACT_ARM: begin
                st_d.valid = 1'b1;
                st_d.addr  = lr_addr;
            end
            resv_pkg::ACT_DROP: st_d.valid = 1'b0;
            default:            st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{valid: 1'b0, addr: '0};
        else        st_q <= st_d;
    end

    assign valid_q   = st_q.valid;
    assign sc_ok     = sc_fire & valid_q & addr_same;
    assign resv_addr = valid_q ? st_q.addr : '1;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lr_fire,
    input logic [ADDR_W-1:0] lr_addr,
    input logic              sc_fire,
    input logic              trap_take,
    input logic              trap_ret,
    input logic              resv_keep,
    input logic              sc_ok,
    input logic [ADDR_W-1:0] resv_addr,
    input logic              valid_q
);
    // R1
    lr_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_fire |=> (valid_q && resv_addr == $past(lr_addr)));

    // R3
    sc_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !lr_fire) |=> !valid_q);

    // R4
    sc_idle_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !valid_q) |-> !sc_ok);

    // R5
    keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!resv_keep && !lr_fire) |=> !valid_q);

    // R6
    trap_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_take || trap_ret) && !lr_fire) |=> !valid_q);

    // R8
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> (resv_addr == '1));
endmodule

bind resv_monitor resv_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lr_fire   (lr_fire),
    .lr_addr   (lr_addr),
    .sc_fire   (sc_fire),
    .trap_take (trap_take),
    .trap_ret  (trap_ret),
    .resv_keep (resv_keep),
    .sc_ok     (sc_ok),
    .resv_addr (resv_addr),
    .valid_q   (valid_q)
);

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
    localparam int unsigned AW   = 32;
    localparam logic [AW-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lr_fire = 0, sc_fire = 0, amo_fire = 0, trap_take = 0, trap_ret = 0, resv_keep = 1;
    logic [AW-1:0] lr_addr = '0, sc_addr = '0;
    logic sc_ok_w, sc_ok_n;
    logic [AW-1:0] ra_w, ra_n;
    int vectors = 0, miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Wide granule (8 bytes), atomic operations ignored
    resv_monitor #(.ADDR_W(AW), .GRANULE_BYTES(8), .AMO_CANCELS(1'b0)) u_resv_monitor (
        .clk(clk), .rst_n(rst_n), .lr_fire(lr_fire), .lr_addr(lr_addr),
        .sc_fire(sc_fire), .sc_addr(sc_addr), .amo_fire(amo_fire),
        .trap_take(trap_take), .trap_ret(trap_ret), .resv_keep(resv_keep),
        .sc_ok(sc_ok_w), .resv_addr(ra_w));

    // Byte granule, atomic operations cancel
    resv_monitor #(.ADDR_W(AW), .GRANULE_BYTES(1), .AMO_CANCELS(1'b1)) u_resv_monitor_n (
        .clk(clk), .rst_n(rst_n), .lr_fire(lr_fire), .lr_addr(lr_addr),
        .sc_fire(sc_fire), .sc_addr(sc_addr), .amo_fire(amo_fire),
        .trap_take(trap_take), .trap_ret(trap_ret), .resv_keep(resv_keep),
        .sc_ok(sc_ok_n), .resv_addr(ra_n));

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        lr_fire = 0; sc_fire = 0; amo_fire = 0; trap_take = 0; trap_ret = 0; resv_keep = 1;
    endtask

    // apply current inputs for one clock, then return to idle
    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    task automatic do_lr(input logic [AW-1:0] a);
        lr_fire = 1; lr_addr = a; tick();
    endtask

    task automatic t_reset();
        check("R9 reset wide", ra_w, ONES);
        check("R8 reset narrow", ra_n, ONES);
    endtask

    task automatic t_lr_sc_granule();
        do_lr(32'h0000_1000);
        check("R1 armed wide", ra_w, 32'h0000_1000);
        check("R1 armed narrow", ra_n, 32'h0000_1000);
        sc_fire = 1; sc_addr = 32'h0000_1004; #1;
        check("R2 same granule pass", {31'd0, sc_ok_w}, 1);
        check("R2 byte granule fail", {31'd0, sc_ok_n}, 0);
        tick();
        check("R3 disarmed after pass", ra_w, ONES);
        check("R3 disarmed after fail", ra_n, ONES);
        sc_fire = 1; sc_addr = 32'h0000_1000; #1;
        check("R4 no reservation fails", {31'd0, sc_ok_w | sc_ok_n}, 0);
        tick();
        do_lr(32'h0000_2000);
        sc_fire = 1; sc_addr = 32'h0000_2008; #1;
        check("R2 next granule fails", {31'd0, sc_ok_w}, 0);
        tick();
        do_lr(32'h0000_3003);
        sc_fire = 1; sc_addr = 32'h0000_3003; #1;
        check("R2 exact pass narrow", {31'd0, sc_ok_n}, 1);
        tick();
    endtask

    task automatic t_cancels();
        do_lr(32'h0000_4000);
        resv_keep = 0; tick();
        check("R5 keep low", ra_w, ONES);
        do_lr(32'h0000_4000);
        trap_take = 1; tick();
        check("R6 trap taken", ra_w, ONES);
        do_lr(32'h0000_4000);
        trap_ret = 1; tick();
        check("R6 trap return", ra_n, ONES);
        do_lr(32'h0000_5000);
        amo_fire = 1; tick();
        check("R7 amo ignored", ra_w, 32'h0000_5000);
        check("R7 amo cancels", ra_n, ONES);
        sc_fire = 1; sc_addr = 32'h0000_5000; #1;
        check("R7 reservation still usable", {31'd0, sc_ok_w}, 1);
        tick();
    endtask

    task automatic t_collide();
        lr_fire = 1; lr_addr = 32'h0000_6000; trap_take = 1; resv_keep = 0; tick();
        check("R10 lr beats trap", ra_w, 32'h0000_6000);
        lr_fire = 1; lr_addr = 32'h0000_7000; amo_fire = 1; trap_ret = 1; tick();
        check("R10 lr beats amo", ra_n, 32'h0000_7000);
        lr_fire = 1; lr_addr = 32'h0000_8000; sc_fire = 1; sc_addr = 32'h0000_7000; #1;
        check("R10 sc judged on old", {31'd0, sc_ok_n}, 1);
        tick();
        check("R10 new lr survives sc", ra_n, 32'h0000_8000);
        rst_n = 0; tick();
        rst_n = 1;
        check("R9 reset drops", ra_w, ONES);
    endtask

    initial begin
        #200000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_lr_sc_granule();
        t_cancels();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule